// File: doc/BRIEF.md
# Sticky Error Status and Interrupt Output

This block gathers the live error flags of an audio converter (one clock-ratio error on the playback side, one on the capture side, and one overflow flag per capture channel) and turns them into two things a host can use. The first is a status register that remembers every enabled error seen since it was last read and empties itself when it is read. The second is an interrupt pin that follows the enabled errors as a level, for as long as any of them is present.

Software reaches three byte-wide registers through a plain register bus with an address, write data, combinational read data and single-cycle write and read strobes. The first is a control register that selects how the pin signals an interrupt: driven high, driven low, or pulled low by an open-drain driver. The second is the status register, which software can only read. The third is an enable mask for the status bits and for the interrupt. The open-drain style is shown as a pin level together with an output enable.

Top module: `err_status_irq`

## Requirements
- R1: After reset the mode field is 00, the mask is all zeros, the status is all zeros, `irq_pin` is 0 and `irq_oe` is 1.
- R2: The control register is at address 0x18. Its interrupt mode field is bits [3:2] and reads back as written. Bits [7:4] and [1:0] read as 0, and writes to them are ignored.
- R3: The mask register is at address 0x1A. Bits [4:0] are read/write and reset to 0. A 1 enables the matching status bit. Bits [7:5] read as 0.
- R4: The status register is at address 0x19. Its bits are: bit 0 overflow of channel 1, bit 1 channel 2, bit 2 channel 3, bit 3 capture clock error, bit 4 playback clock error, and [7:5] read 0. An enabled bit reads 1 once its error has been seen at a clock edge since the last status read.
- R5: A read strobe at address 0x19 returns the current value and clears every status bit at that clock edge. An enabled error that is present at the same edge sets its bit again.
- R6: A status bit whose mask bit is 0 always reads 0. This holds for errors that arrive while the bit is masked and for bits captured before the mask was cleared.
- R7: A write to address 0x19 changes no status bit.
- R8: The raw interrupt is the OR of all live errors whose mask bit is 1. The pin outputs are registered and show the raw interrupt and the mode as they were at the previous clock edge. Mode 00 gives `irq_oe`=1 and `irq_pin`=raw.
- R9: Mode 01 (active low) gives `irq_oe`=1 and `irq_pin`=not raw.
- R10: Mode 10 (open drain) gives `irq_pin`=0 and `irq_oe`=raw, so the pin is driven only while pulling low.
- R11: Mode 11 holds the pin inactive: `irq_pin`=0 and `irq_oe`=0.
- R12: Any other address reads 0, and a read strobe at such an address leaves the status untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_ovfl | input | 3 | Live overflow flags of capture channels 1..3 |
| err_adc_clk | input | 1 | Live capture clock-ratio error |
| err_dac_clk | input | 1 | Live playback clock-ratio error |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access; a read of the status clears it |
| reg_rdata | output | 8 | Read data of the addressed register, combinational |
| irq_pin | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable (0 means high impedance) |

## Verification
The assertions assume that the error flags and the bus strobes are synchronous to `clk` and never unknown. They also assume that a read strobe lasts one cycle per intended access, because each cycle it is high at the status address counts as a separate clearing read. The stimulus drives every input just after the falling edge, so every value is stable before the next rising edge. The random phase mixes sparse and dense error patterns with reads, writes and stray addresses. Directed cases cover a read and an error at the same edge, a mask change after capture, writes to the read-only address, and all four pin modes.

// File: rtl/err_status_pkg.sv
package err_status_pkg;

  // Interrupt pin signalling style, encoded as in the control register field.
  typedef enum logic [1:0] {
    PIN_HIGH = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_OD   = 2'b10,
    PIN_OFF  = 2'b11
  } pin_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/esi_cfg_regs.sv
module esi_cfg_regs
  import err_status_pkg::*;
#(
  parameter int unsigned ST_W = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            wr_mode_i,
  input  logic [1:0]      wmode_i,
  input  logic            wr_mask_i,
  input  logic [ST_W-1:0] wmask_i,
  output pin_mode_e       mode_o,
  output logic [ST_W-1:0] mask_o
);

  pin_mode_e       mode_q, mode_d;
  logic [ST_W-1:0] mask_q, mask_d;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    if (wr_mode_i) mode_d = pin_mode_e'(wmode_i);
    if (wr_mask_i) mask_d = wmask_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PIN_HIGH;
      mask_q <= '0;
    end else begin
      if (wr_mode_i) mode_q <= mode_d;
      if (wr_mask_i) mask_q <= mask_d;
    end
  end

  assign mode_o = mode_q;
  assign mask_o = mask_q;

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_mask_i |=> $stable(mask_o)); // R3
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_mode_i |=> (mode_o == $past(wmode_i))); // R2

endmodule

// File: rtl/esi_sticky.sv
module esi_sticky #(
  parameter int unsigned ST_W = 5
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] live_i,
  input  logic [ST_W-1:0] mask_i,
  input  logic            clr_i,
  output logic [ST_W-1:0] sticky_o
);

  logic [ST_W-1:0] sticky_q, sticky_d, hit;

  assign hit = live_i & mask_i;

  always_comb begin
    sticky_d = clr_i ? '0 : sticky_q;
    sticky_d = sticky_d | hit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= sticky_d;
  end

  assign sticky_o = sticky_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o))); // R4
  AST_SET_ON_ERR: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(live_i & mask_i)) |=> ((sticky_o & $past(live_i & mask_i)) == $past(live_i & mask_i))); // R4
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> (sticky_o == $past(live_i & mask_i))); // R5

endmodule

// File: rtl/esi_pin_drv.sv
module esi_pin_drv
  import err_status_pkg::*;
(
  input  logic      clk,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      raw_i,
  output logic      pin_o,
  output logic      oe_o
);

  logic pin_q, pin_d, oe_q, oe_d;

  always_comb begin
    unique case (mode_i)
      PIN_HIGH: begin pin_d = raw_i;  oe_d = 1'b1;  end
      PIN_LOW:  begin pin_d = !raw_i; oe_d = 1'b1;  end
      PIN_OD:   begin pin_d = 1'b0;   oe_d = raw_i; end
      default:  begin pin_d = 1'b0;   oe_d = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      pin_q <= pin_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_o = pin_q;
  assign oe_o  = oe_q;

  AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == PIN_HIGH) |=> (oe_o && (pin_o == $past(raw_i)))); // R8
  AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == PIN_LOW) |=> (oe_o && (pin_o == !$past(raw_i)))); // R9
  AST_PIN_OD: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == PIN_OD) |=> (!pin_o && (oe_o == $past(raw_i)))); // R10
  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode_i == PIN_OFF) |=> (!pin_o && !oe_o)); // R11
  AST_HIGH_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_ni)
    pin_o |-> oe_o); // R10

endmodule

// File: rtl/err_status_irq.sv
module err_status_irq
  import err_status_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned N_OVFL    = 3,
  parameter int unsigned MODE_LSB  = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h18,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h19,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_OVFL-1:0] err_ovfl,
  input  logic              err_adc_clk,
  input  logic              err_dac_clk,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin,
  output logic              irq_oe
);

  localparam int unsigned ST_W = N_OVFL + 2;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      rst_sync_n <= rst_s1_q;
    end
  end

  logic [ST_W-1:0] live, mask, sticky;
  pin_mode_e       mode;
  logic            sel_ctrl, sel_stat, sel_mask, raw_irq;

  assign live     = {err_dac_clk, err_adc_clk, err_ovfl};
  assign sel_ctrl = (reg_addr == CTRL_ADDR);
  assign sel_stat = (reg_addr == STAT_ADDR);
  assign sel_mask = (reg_addr == MASK_ADDR);
  assign raw_irq  = |(live & mask);

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:ST_W];

  esi_cfg_regs #(.ST_W(ST_W)) i_cfg (
    .clk       (clk),
    .rst_ni    (rst_sync_n),
    .wr_mode_i (reg_wr && sel_ctrl),
    .wmode_i   (reg_wdata[MODE_LSB +: MODE_W]),
    .wr_mask_i (reg_wr && sel_mask),
    .wmask_i   (reg_wdata[ST_W-1:0]),
    .mode_o    (mode),
    .mask_o    (mask)
  );

  esi_sticky #(.ST_W(ST_W)) i_sticky (
    .clk      (clk),
    .rst_ni   (rst_sync_n),
    .live_i   (live),
    .mask_i   (mask),
    .clr_i    (reg_rd && sel_stat),
    .sticky_o (sticky)
  );

  esi_pin_drv i_pin (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .mode_i (mode),
    .raw_i  (raw_irq),
    .pin_o  (irq_pin),
    .oe_o   (irq_oe)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl)      reg_rdata[MODE_LSB +: MODE_W] = mode;
    else if (sel_stat) reg_rdata[ST_W-1:0] = sticky & mask;
    else if (sel_mask) reg_rdata[ST_W-1:0] = mask;
  end

  AST_STAT_MASKED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && sel_stat) |-> ((reg_rdata[ST_W-1:0] & ~mask) == '0)); // R6
  AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_rd && sel_ctrl) |-> (reg_rdata[DATA_W-1:MODE_LSB+MODE_W] == '0 &&
                              reg_rdata[MODE_LSB-1:0] == '0)); // R2
  AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && sel_stat && !reg_rd && !(|(live & mask))) |=> $stable(sticky)); // R7
  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sel_ctrl && !sel_stat && !sel_mask) |-> (reg_rdata == '0)); // R12

endmodule

// File: tb/test_err_status_irq.sv
module test_err_status_irq;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h18, A_STAT = 8'h19, A_MASK = 8'h1A;

  logic       clk, rst_n;
  logic [2:0] err_ovfl;
  logic       err_adc_clk, err_dac_clk;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr, reg_rd, irq_pin, irq_oe;

  int errors = 0;
  int checks = 0;

  logic [1:0] m_mode;
  logic [4:0] m_mask, m_sticky;

  err_status_irq i_err_status_irq (
    .clk(clk), .rst_n(rst_n), .err_ovfl(err_ovfl), .err_adc_clk(err_adc_clk),
    .err_dac_clk(err_dac_clk), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .irq_pin(irq_pin), .irq_oe(irq_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == A_CTRL) return {4'b0, m_mode, 2'b0};
    if (a == A_STAT) return {3'b0, m_sticky & m_mask};
    if (a == A_MASK) return {3'b0, m_mask};
    return 8'h00;
  endfunction

  function automatic string req_of_addr(input logic [7:0] a);
    if (a == A_CTRL) return "R2";
    if (a == A_STAT) return "R4";
    if (a == A_MASK) return "R3";
    return "R12";
  endfunction

  // {pin, oe} for a mode and raw interrupt
  function automatic logic [1:0] exp_pin(input logic [1:0] md, input logic raw);
    case (md)
      2'b00:   return {raw, 1'b1};
      2'b01:   return {~raw, 1'b1};
      2'b10:   return {1'b0, raw};
      default: return 2'b00;
    endcase
  endfunction

  function automatic string req_of_mode(input logic [1:0] md);
    case (md)
      2'b00:   return "R8";
      2'b01:   return "R9";
      2'b10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  // One bus cycle: drive after falling edge, check read data, then model the edge and check the pin.
  task automatic cyc(input logic [4:0] live, input logic [7:0] a, input logic [7:0] wd,
                     input logic w, input logic r, input string tag);
    logic [1:0] pe;
    string      rq;
    @(negedge clk);
    {err_dac_clk, err_adc_clk, err_ovfl} = live;
    reg_addr = a; reg_wdata = wd; reg_wr = w; reg_rd = r;
    #1;
    if (r) chk((tag != "") ? tag : req_of_addr(a), reg_rdata, exp_read(a));
    @(posedge clk);
    pe = exp_pin(m_mode, |(live & m_mask));
    rq = req_of_mode(m_mode);
    m_sticky = ((r && a == A_STAT) ? 5'b0 : m_sticky) | (live & m_mask);
    if (w && a == A_CTRL) m_mode = wd[3:2];
    if (w && a == A_MASK) m_mask = wd[4:0];
    #1;
    chk(rq, {6'b0, irq_pin, irq_oe}, {6'b0, pe});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(5'b0, 8'h00, 8'h00, 1'b0, 1'b0, "");
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    err_ovfl = '0; err_adc_clk = 1'b0; err_dac_clk = 1'b0;
    reg_addr = '0; reg_wdata = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    m_mode = 2'b00; m_mask = '0; m_sticky = '0;
    repeat (3) @(negedge clk);
    chk("R1", {6'b0, irq_pin, irq_oe}, 8'h01);
    rst_n = 1'b1;
    idle(4);
    // R1: reset register values
    cyc(5'b0, A_CTRL, 8'h00, 1'b0, 1'b1, "R1");
    cyc(5'b0, A_MASK, 8'h00, 1'b0, 1'b1, "R1");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R1");

    // R6: errors while masked never show
    cyc(5'h1F, 8'h00, 8'h00, 1'b0, 1'b0, "");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R6");
    chk("R6", reg_rdata, 8'h00);

    // R3: mask write, reserved bits read 0
    cyc(5'b0, A_MASK, 8'hFF, 1'b1, 1'b0, "");
    cyc(5'b0, A_MASK, 8'h00, 1'b0, 1'b1, "R3");

    // R4: capture one error after it goes away
    cyc(5'b00100, 8'h00, 8'h00, 1'b0, 1'b0, "");
    idle(2);
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R4");
    // R5: second read shows cleared
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R5");
    // R5: error at the same edge as the clearing read
    cyc(5'b00001, 8'h00, 8'h00, 1'b0, 1'b0, "");
    cyc(5'b01000, A_STAT, 8'h00, 1'b0, 1'b1, "R5");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R5");

    // R7: writing the status address changes nothing
    cyc(5'b10000, 8'h00, 8'h00, 1'b0, 1'b0, "");
    cyc(5'b0, A_STAT, 8'h00, 1'b1, 1'b0, "");
    cyc(5'b0, A_STAT, 8'hFF, 1'b1, 1'b0, "");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R7");

    // R6: bit captured then masked off reads 0
    cyc(5'b00010, 8'h00, 8'h00, 1'b0, 1'b0, "");
    cyc(5'b0, A_MASK, 8'h1D, 1'b1, 1'b0, "");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R6");
    cyc(5'b0, A_MASK, 8'h1F, 1'b1, 1'b0, "");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R6");

    // R12: stray address reads 0 and does not clear
    cyc(5'b00001, 8'h00, 8'h00, 1'b0, 1'b0, "");
    cyc(5'b0, 8'h20, 8'h00, 1'b0, 1'b1, "R12");
    cyc(5'b0, A_STAT, 8'h00, 1'b0, 1'b1, "R12");

    // R2: reserved control bits ignored
    cyc(5'b0, A_CTRL, 8'hFF, 1'b1, 1'b0, "");
    cyc(5'b0, A_CTRL, 8'h00, 1'b0, 1'b1, "R2");

    // R8..R11: each pin mode with the interrupt toggling
    for (int md = 0; md < 4; md++) begin
      cyc(5'b0, A_CTRL, 8'(md << 2), 1'b1, 1'b0, "");
      cyc(5'b00100, 8'h00, 8'h00, 1'b0, 1'b0, "");
      cyc(5'b00100, 8'h00, 8'h00, 1'b0, 1'b0, "");
      cyc(5'b0, 8'h00, 8'h00, 1'b0, 1'b0, "");
      cyc(5'b0, 8'h00, 8'h00, 1'b0, 1'b0, "");
    end

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] lv;
      logic [7:0] a;
      int         sel;
      lv = (i % 2 == 0) ? 5'($urandom & $urandom & $urandom) : 5'($urandom);
      sel = int'($urandom % 8);
      case (sel)
        0, 1:    a = A_STAT;
        2:       a = A_CTRL;
        3:       a = A_MASK;
        default: a = 8'($urandom);
      endcase
      cyc(lv, a, 8'($urandom), ($urandom % 6) == 0, ($urandom % 3) == 0, "");
    end

    report();
  end

endmodule